// File: doc/BRIEF.md
# Millisecond interval timer

A down-counting timer whose interval is set in whole milliseconds through a small register port. A six-bit count chooses an interval of 1 to 63 ms, and a count of zero keeps the timer off. A mode bit chooses one of two behaviours. In single-run mode the timer stops when it reaches its end. In repeating mode it reloads its count and runs again. An idle-level bit sets the output waveform level while the timer is off.

Writing a non-zero count starts the timer at once. Writing it again before expiry restarts the timer from the new count. Writing zero stops it. While the timer runs, the waveform output is high for the first half of each interval and low for the second half, so one output period equals the programmed interval. Each expiry sets a sticky flag. The interrupt output is that flag gated by an enable bit.

An internal prescaler divides the system clock down to a half-millisecond tick, so the half-interval edges fall exactly on time even for odd counts.

Top module: `ms_interval_timer`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, and both `wave_o` and `irq_o` are 0.
- R2: Register 0 holds the count in bits [5:0], the repeating-mode bit in bit 6 and the idle level in bit 7. Register 1 holds the expiry flag in bit 0 and the interrupt enable in bit 1. A read returns the programmed values, not the live counter.
- R3: A write of a non-zero count to register 0 drives `wave_o` high from the clock edge that takes the write.
- R4: With count N and H clock cycles per half millisecond, `wave_o` falls N·H cycles after the starting edge and the timer expires 2·N·H cycles after it. This holds for odd N and for N = 63.
- R5: In single-run mode the timer stops at expiry. `wave_o` returns to the idle level and no further edges or expiries follow.
- R6: In repeating mode, each expiry drives `wave_o` high again and starts a new interval of the same length, without a gap.
- R7: A non-zero write before expiry discards the running interval and times a full interval of the new count from the write.
- R8: A write of count 0 stops the timer at once. `wave_o` takes the idle level and no expiry follows.
- R9: Each expiry sets the flag. Writing 1 to status bit 0 clears the flag, and writing 0 to that bit leaves it unchanged.
- R10: `irq_o` is high only while both the flag and the enable are set. With the enable clear, an expiry still sets the flag but `irq_o` stays 0.
- R11: While the timer is off, `wave_o` follows the idle-level bit, including when that bit is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | CNT_W+2 | Write data |
| rd_data | output | CNT_W+2 | Read data for the register at `reg_addr` |
| wave_o | output | 1 | Square-wave output, at the idle level when the timer is off |
| irq_o | output | 1 | Expiry interrupt: flag AND enable |

## Verification
The timer is driven with five patterns:
- An odd count in single-run mode. It separates a half-interval edge that is rounded from one that is exact, and shows whether the timer really stops.
- A short count in repeating mode with a non-zero idle level. It shows whether the reload leaves a gap and whether a stop lands on the idle level.
- A one-millisecond run with the interrupt masked. It separates the flag from the interrupt pin.
- A rewrite partway through a long interval. It tells a true restart from a timer that keeps the old expiry.
- The largest count. It exercises the top of the counter range.

A scoreboard predicts each waveform edge and interrupt rise with its cycle. Any missing, late or extra event shows up against that prediction.

// File: rtl/msit_pkg.sv
package msit_pkg;
   // register select
   typedef enum logic {
      MSIT_REG_CTRL = 1'b0,
      MSIT_REG_STAT = 1'b1
   } msit_reg_e;

   // status register bit positions
   localparam int unsigned MSIT_STAT_FLAG = 0;
   localparam int unsigned MSIT_STAT_EN   = 1;

   // prescaler output rate: two ticks per millisecond
   localparam int unsigned MSIT_TICKS_PER_SEC = 2000;
endpackage

// File: rtl/msit_prescaler.sv
module msit_prescaler #(
   parameter int unsigned HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   generate
      if (HALF_CYC == 1) begin : g_direct
         // every clock is a half-millisecond tick
         assign tick = !restart;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (restart)        cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST) && !restart;
      end
   endgenerate
endmodule

// File: rtl/msit_countdown.sv
module msit_countdown #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             stop,
   input  logic             cyclic,
   input  logic             idle,
   input  logic             tick,
   output logic             running,
   output logic             wave_o,
   output logic             expire
);
   // remaining half-millisecond ticks, up to twice the count
   localparam int unsigned REM_W = CNT_W + 1;
   localparam logic [REM_W-1:0] REM_ONE = REM_W'(1);

   logic [REM_W-1:0] rem_q;
   logic [CNT_W-1:0] n_q;
   logic             wave_q;
   logic             run_q;
   logic             at_end;
   logic             at_half;

   assign at_end  = (rem_q == REM_ONE);
   assign at_half = (rem_q == ({1'b0, n_q} + REM_ONE));
   assign expire  = run_q && tick && at_end && !load && !stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         rem_q  <= '0;
         n_q    <= '0;
         wave_q <= 1'b0;
      end else if (load) begin
         run_q  <= 1'b1;
         n_q    <= load_cnt;
         rem_q  <= {load_cnt, 1'b0};
         wave_q <= 1'b1;
      end else if (stop) begin
         run_q  <= 1'b0;
         wave_q <= 1'b0;
      end else if (run_q && tick) begin
         if (at_end) begin
            if (cyclic) begin
               rem_q  <= {n_q, 1'b0};
               wave_q <= 1'b1;
            end else begin
               run_q  <= 1'b0;
               wave_q <= 1'b0;
            end
         end else begin
            rem_q <= rem_q - REM_ONE;
            if (at_half) wave_q <= 1'b0;
         end
      end
   end

   assign running = run_q;
   assign wave_o  = run_q ? wave_q : idle;
endmodule

// File: rtl/msit_irq.sv
module msit_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic stat_wr,
   input  logic clr_bit,
   input  logic en_bit,
   output logic flag,
   output logic en_q,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         en_q <= 1'b0;
      end else begin
         // a fresh expiry outranks a simultaneous clear
         if (expire)                  flag <= 1'b1;
         else if (stat_wr && clr_bit) flag <= 1'b0;
         if (stat_wr)                 en_q <= en_bit;
      end
   end

   assign irq_o = flag & en_q;
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer #(
   parameter int unsigned CLK_HZ = 50_000_000,
   parameter int unsigned CNT_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_addr,
   input  logic [CNT_W+1:0]   reg_wdata,
   output logic [CNT_W+1:0]   rd_data,
   output logic               wave_o,
   output logic               irq_o
);
   import msit_pkg::*;

   localparam int unsigned REG_W    = CNT_W + 2;
   localparam int unsigned HALF_CYC = CLK_HZ / MSIT_TICKS_PER_SEC;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
         $error("ms_interval_timer: CNT_W must lie in 1..16");
      end
      if (CLK_HZ < MSIT_TICKS_PER_SEC || (CLK_HZ % MSIT_TICKS_PER_SEC) != 0) begin : g_bad_clk
         $error("ms_interval_timer: CLK_HZ must be a multiple of 2000");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;
   logic             mode_q;
   logic             idle_q;
   logic             ctrl_wr;
   logic             stat_wr;
   logic             start;
   logic             stop;
   logic             tick;
   logic             running;
   logic             expire;
   logic             flag;
   logic             en_q;

   assign ctrl_wr = reg_wr && (msit_reg_e'(reg_addr) == MSIT_REG_CTRL);
   assign stat_wr = reg_wr && (msit_reg_e'(reg_addr) == MSIT_REG_STAT);
   assign start   = ctrl_wr && (reg_wdata[CNT_W-1:0] != '0);
   assign stop    = ctrl_wr && (reg_wdata[CNT_W-1:0] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         mode_q  <= 1'b0;
         idle_q  <= 1'b0;
      end else if (ctrl_wr) begin
         count_q <= reg_wdata[CNT_W-1:0];
         mode_q  <= reg_wdata[CNT_W];
         idle_q  <= reg_wdata[CNT_W+1];
      end
   end

   msit_prescaler #(.HALF_CYC(HALF_CYC)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .tick    (tick)
   );

   msit_countdown #(.CNT_W(CNT_W)) u_cd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_cnt (reg_wdata[CNT_W-1:0]),
      .stop     (stop),
      .cyclic   (mode_q),
      .idle     (idle_q),
      .tick     (tick),
      .running  (running),
      .wave_o   (wave_o),
      .expire   (expire)
   );

   msit_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .expire  (expire),
      .stat_wr (stat_wr),
      .clr_bit (reg_wdata[MSIT_STAT_FLAG]),
      .en_bit  (reg_wdata[MSIT_STAT_EN]),
      .flag    (flag),
      .en_q    (en_q),
      .irq_o   (irq_o)
   );

   always_comb begin
      rd_data = '0;
      if (msit_reg_e'(reg_addr) == MSIT_REG_CTRL) begin
         rd_data = {idle_q, mode_q, count_q};
      end else begin
         rd_data[MSIT_STAT_FLAG] = flag;
         rd_data[MSIT_STAT_EN]   = en_q;
      end
   end
endmodule

// File: rtl/msit_checker.sv
module msit_checker #(
   parameter int unsigned CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stat_wr,
   input logic [CNT_W+1:0] reg_wdata,
   input logic             start,
   input logic             stop,
   input logic             running,
   input logic             expire,
   input logic             mode_q,
   input logic             idle_q,
   input logic             wave_o,
   input logic             flag,
   input logic             en_q,
   input logic             irq_o
);
   // R3
   start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (running && wave_o));

   // R8
   zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!running && (wave_o == idle_q)));

   // R5
   single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !mode_q && !start && !stop) |=> !running);

   // R6
   repeat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && mode_q && !start && !stop) |=> (running && wave_o));

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(stat_wr && reg_wdata[0])) |=> flag);

   // R10
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !irq_o);
endmodule

bind ms_interval_timer msit_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stat_wr   (stat_wr),
   .reg_wdata (reg_wdata),
   .start     (start),
   .stop      (stop),
   .running   (running),
   .expire    (expire),
   .mode_q    (mode_q),
   .idle_q    (idle_q),
   .wave_o    (wave_o),
   .flag      (flag),
   .en_q      (en_q),
   .irq_o     (irq_o)
);

// File: tb/ms_interval_timer_bench.sv
`timescale 1ns/1ps
module ms_interval_timer_bench;
   localparam int H = 4;               // cycles per half millisecond at CLK_HZ=8000
   localparam int K_WAVE = 0;
   localparam int K_IRQ  = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] rd_data;
   logic       wave;
   logic       irq;

   always #2 clk = ~clk;

   ms_interval_timer #(.CLK_HZ(8000), .CNT_W(6)) u_ms_interval_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .rd_data   (rd_data),
      .wave_o    (wave),
      .irq_o     (irq)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0;
   int bad = 0;
   bit mon_on = 0;
   bit done = 0;
   logic pw = 1'b0;
   logic pi = 1'b0;

   int    q_cyc[$];
   int    q_kind[$];
   int    q_val[$];
   string q_req[$];

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic expect_ev(int c, int k, int v, string req);
      q_cyc.push_back(c);
      q_kind.push_back(k);
      q_val.push_back(v);
      q_req.push_back(req);
   endtask

   task automatic pop_cmp(int k, int v);
      if (q_cyc.size() == 0) begin
         chk(1'b0, "R5", (k == K_WAVE) ? "unexpected wave edge at cycle" : "unexpected irq rise at cycle", cyc, -1);
      end else begin
         int    c  = q_cyc.pop_front();
         int    kk = q_kind.pop_front();
         int    vv = q_val.pop_front();
         string rq = q_req.pop_front();
         chk(c == cyc && kk == k && vv == v, rq,
             (kk == K_WAVE) ? "wave edge cycle" : "irq rise cycle", cyc, c);
      end
   endtask

   // monitor: compares every observed event against the scoreboard
   always @(negedge clk) begin
      if (mon_on) begin
         if (wave !== pw) pop_cmp(K_WAVE, int'(wave));
         if (irq && !pi)  pop_cmp(K_IRQ, 1);
      end
      pw = wave;
      pi = irq;
   end

   task automatic arm(output int t);
      @(negedge clk);
      t = cyc + 1;
   endtask

   task automatic fire(logic a, logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic wr(logic a, logic [7:0] d);
      @(negedge clk);
      fire(a, d);
   endtask

   task automatic rd(logic a, logic [7:0] exp, string req, string what);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(rd_data == exp, req, what, int'(rd_data), int'(exp));
   endtask

   task automatic wait_until(int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic drain(string req);
      chk(q_cyc.size() == 0, req, "pending expected events", q_cyc.size(), 0);
   endtask

   initial begin
      int t0;
      int t1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(wave == 1'b0, "R1", "wave after reset", int'(wave), 0);
      chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
      rd(1'b0, 8'h00, "R1", "control after reset");
      rd(1'b1, 8'h00, "R1", "status after reset");
      mon_on = 1;

      // R2 enable interrupt
      wr(1'b1, 8'h02);
      rd(1'b1, 8'h02, "R2", "status enable readback");

      // R3 R4 R5: single run, odd count 3, idle 0
      arm(t0);
      expect_ev(t0, K_WAVE, 1, "R3");
      expect_ev(t0 + 3*H, K_WAVE, 0, "R4");
      expect_ev(t0 + 6*H, K_IRQ, 1, "R4");
      fire(1'b0, 8'h03);
      wait_until(t0 + 6*H + 20);
      drain("R5");
      chk(wave == 1'b0, "R5", "wave idle after single run", int'(wave), 0);
      rd(1'b0, 8'h03, "R2", "control readback");
      rd(1'b1, 8'h03, "R9", "flag set after expiry");

      // R9 clear semantics
      wr(1'b1, 8'h02);
      rd(1'b1, 8'h03, "R9", "flag kept when bit0 written 0");
      wr(1'b1, 8'h03);
      rd(1'b1, 8'h02, "R9", "flag cleared by write-one");
      chk(irq == 1'b0, "R9", "irq after clear", int'(irq), 0);

      // R6 R8: repeating, count 2, idle 1
      arm(t0);
      expect_ev(t0, K_WAVE, 1, "R3");
      expect_ev(t0 + 2*H, K_WAVE, 0, "R6");
      expect_ev(t0 + 4*H, K_WAVE, 1, "R6");
      expect_ev(t0 + 4*H, K_IRQ, 1, "R6");
      expect_ev(t0 + 6*H, K_WAVE, 0, "R6");
      expect_ev(t0 + 8*H, K_WAVE, 1, "R6");
      expect_ev(t0 + 10*H, K_WAVE, 0, "R6");
      fire(1'b0, 8'hC2);
      wait_until(t0 + 10*H + 2);
      arm(t1);
      expect_ev(t1, K_WAVE, 1, "R8");
      fire(1'b0, 8'h80);
      wait_until(t1 + 60);
      drain("R8");
      chk(wave == 1'b1, "R11", "wave at idle level 1", int'(wave), 1);
      rd(1'b0, 8'h80, "R2", "control after stop");

      // R11 idle level rewrite while off
      arm(t1);
      expect_ev(t1, K_WAVE, 0, "R11");
      fire(1'b0, 8'h00);
      repeat (4) @(negedge clk);
      drain("R11");

      // R10 masked: clear flag, disable, count 1
      wr(1'b1, 8'h01);
      arm(t0);
      expect_ev(t0, K_WAVE, 1, "R3");
      expect_ev(t0 + H, K_WAVE, 0, "R4");
      fire(1'b0, 8'h01);
      wait_until(t0 + 2*H + 10);
      drain("R10");
      rd(1'b1, 8'h01, "R10", "flag set with enable clear");
      chk(irq == 1'b0, "R10", "irq while masked", int'(irq), 0);

      // R7 rewrite before expiry
      wr(1'b1, 8'h03);
      arm(t0);
      expect_ev(t0, K_WAVE, 1, "R3");
      fire(1'b0, 8'h05);
      wait_until(t0 + 2*H);
      arm(t1);
      expect_ev(t1 + 2*H, K_WAVE, 0, "R7");
      expect_ev(t1 + 4*H, K_IRQ, 1, "R7");
      fire(1'b0, 8'h02);
      wait_until(t0 + 10*H + 30);
      drain("R7");
      rd(1'b1, 8'h03, "R7", "flag after restarted run");

      // R4 largest count
      wr(1'b1, 8'h03);
      arm(t0);
      expect_ev(t0, K_WAVE, 1, "R3");
      expect_ev(t0 + 63*H, K_WAVE, 0, "R4");
      expect_ev(t0 + 126*H, K_IRQ, 1, "R4");
      fire(1'b0, 8'h3F);
      wait_until(t0 + 126*H + 20);
      drain("R4");
      rd(1'b0, 8'h3F, "R2", "control max count");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule